// File: doc/BRIEF.md
# Interrupt Notification Message Generator

This block is the front end of an interrupt controller that reports events as memory writes rather than as wires. It keeps one level bit per interrupt source, updated by assert and deassert events. It also accepts triggers, each tagged with a source number. For every accepted trigger it builds a 64-bit notification word and issues it as a single write request to an address that software programs. Software reaches the block through 8-byte registers at fixed byte offsets: an interrupt-control word, a page base with a valid flag, a notification address with a valid flag, and an interrupt-number offset. A read-only view of the level bits sits beside them.

The write port uses a request/ready handshake followed by a response that may report an error. Only one write is outstanding at a time. Triggers that arrive while a write is pending wait in a small FIFO. The logic that decides when a source should trigger lies outside this block.

Top module: `intr_notify_gen`

## Requirements
- R1: After reset every register reads as zero, no write request is raised, the sticky error flag is low and the page is unmapped.
- R2: Registers at byte offsets 0x58 (control), 0x60 (page base), 0x68 (notification address) and 0x70 (number offset) read back the last written 64-bit value. Writes to 0x20, 0x28 and 0x78 are ignored. Offsets 0x20 and 0x28 read as zero, and none of these reads flags an error.
- R3: A read of any other byte offset, including a misaligned one, returns all ones with reg_err_o high in the same cycle.
- R4: A level event for source n sets value bit 63−n of the register at 0x78 when its state input is 1, and clears that bit when the state input is 0.
- R5: While control bit 63 (legacy level mode) is set, level events and triggers are ignored.
- R6: A write to 0x58 with bit 62 set clears all level bits and discards every queued trigger in the same cycle. The written value, including bit 62, is then stored. A write that is already in flight still completes.
- R7: Each trigger with notification-address bit 63 set produces one write. Its address is the register value with bit 63 cleared. Its word is TRIG_FLAG OR (value at 0x70 >> 32) OR the source number. The word is placed on wr_data_o in big-endian lane order: bits 7:0 carry the most significant byte.
- R8: When notification-address bit 63 is clear, a trigger produces no write.
- R9: wr_req_o stays high, with address and data stable, until wr_ready_i is seen. No new request starts before wr_rsp_valid_i has ended the previous one.
- R10: Queued triggers are sent in arrival order. With one write in flight, at most FIFO_DEPTH more are held, and later triggers are dropped.
- R11: A response with wr_rsp_err_i set raises err_sticky_o, which stays high until reset. The failed notification is not retried.
- R12: A write of the page base with bit 63 set, while the stored base has bit 63 clear, maps the page at the written value with bit 63 cleared. A write with bit 63 clear unmaps it. A write with bit 63 set while already valid leaves the mapped address unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_req_i | input | 1 | Register access strobe |
| reg_we_i | input | 1 | 1 = write, 0 = read |
| reg_addr_i | input | REG_AW | Register byte offset |
| reg_wdata_i | input | 64 | Register write data |
| reg_rdata_o | output | 64 | Register read data, same cycle |
| reg_err_o | output | 1 | Read of an unlisted offset |
| lvl_evt_i | input | 1 | Level event strobe |
| lvl_src_i | input | SRC_W | Source of the level event |
| lvl_state_i | input | 1 | New level: 1 asserted, 0 deasserted |
| trig_valid_i | input | 1 | Trigger strobe |
| trig_src_i | input | SRC_W | Triggering source number |
| wr_req_o | output | 1 | Notification write request |
| wr_addr_o | output | 64 | Notification target address |
| wr_data_o | output | 64 | Notification word, big-endian lanes |
| wr_ready_i | input | 1 | Write request accepted |
| wr_rsp_valid_i | input | 1 | Write response present |
| wr_rsp_err_i | input | 1 | Write response reports failure |
| err_sticky_o | output | 1 | A notification write has failed |
| page_map_o | output | 1 | Page mapping is active |
| page_addr_o | output | 64 | Address at which the page is mapped |

## Verification
The hardest case to reach is a source reset that lands while a write is stalled and the FIFO holds several entries. In that situation the queue must empty and the level bits must clear, while the in-flight write still finishes. The bench reaches it by holding wr_ready_i low for ten cycles after a burst of four triggers. It issues the control write during that stall and then counts how many writes reach the port. FIFO overflow is reached in a similar way: six back-to-back triggers arrive against a slow responder, and exactly five writes are expected, in order.

// File: rtl/inr_pkg.sv
package inr_pkg;
  localparam logic [7:0] OFF_SPARE0 = 8'h20;
  localparam logic [7:0] OFF_SPARE1 = 8'h28;
  localparam logic [7:0] OFF_CTRL   = 8'h58;
  localparam logic [7:0] OFF_PAGE   = 8'h60;
  localparam logic [7:0] OFF_NADDR  = 8'h68;
  localparam logic [7:0] OFF_IOFF   = 8'h70;
  localparam logic [7:0] OFF_LEVEL  = 8'h78;

  localparam int unsigned LEGACY_BIT = 63;
  localparam int unsigned SRST_BIT   = 62;
  localparam int unsigned VALID_BIT  = 63;

  typedef enum logic [1:0] {SND_IDLE, SND_REQ, SND_WAIT} snd_state_e;

  // most significant byte goes to lane 0
  function automatic logic [63:0] be_lanes(input logic [63:0] v);
    logic [63:0] r;
    for (int i = 0; i < 8; i++) r[8*i +: 8] = v[8*(7-i) +: 8];
    return r;
  endfunction
endpackage

// File: rtl/inr_regs.sv
module inr_regs
  import inr_pkg::*;
#(
  parameter int unsigned NUM_SRC = 14,
  parameter int unsigned SRC_W   = 4,
  parameter int unsigned REG_AW  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [63:0]       wdata_i,
  output logic [63:0]       rdata_o,
  output logic              err_o,
  input  logic              lvl_evt_i,
  input  logic [SRC_W-1:0]  lvl_src_i,
  input  logic              lvl_state_i,
  output logic              legacy_o,
  output logic              src_reset_o,
  output logic [63:0]       naddr_o,
  output logic [31:0]       ioff_o,
  output logic              page_map_o,
  output logic [63:0]       page_addr_o
);
  logic [63:0] ctrl_q, page_q, naddr_q, ioff_q, level_q, page_addr_q;
  logic        wr_en, sel_ctrl, sel_page, sel_naddr, sel_ioff;
  logic [5:0]  lvl_bit;
  logic        lvl_ok;

  assign wr_en     = req_i & we_i;
  assign sel_ctrl  = addr_i == REG_AW'(OFF_CTRL);
  assign sel_page  = addr_i == REG_AW'(OFF_PAGE);
  assign sel_naddr = addr_i == REG_AW'(OFF_NADDR);
  assign sel_ioff  = addr_i == REG_AW'(OFF_IOFF);

  assign src_reset_o = wr_en & sel_ctrl & wdata_i[SRST_BIT];
  assign lvl_bit     = 6'd63 - 6'(lvl_src_i);
  assign lvl_ok      = lvl_evt_i & ~ctrl_q[LEGACY_BIT] & (32'(lvl_src_i) < NUM_SRC);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q      <= '0;
      page_q      <= '0;
      naddr_q     <= '0;
      ioff_q      <= '0;
      page_addr_q <= '0;
    end else if (wr_en) begin
      if (sel_ctrl)  ctrl_q  <= wdata_i;
      if (sel_naddr) naddr_q <= wdata_i;
      if (sel_ioff)  ioff_q  <= wdata_i;
      if (sel_page) begin
        page_q <= wdata_i;
        // remap only on an invalid-to-valid transition
        if (wdata_i[VALID_BIT] && !page_q[VALID_BIT])
          page_addr_q <= {1'b0, wdata_i[62:0]};
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          level_q <= '0;
    else if (src_reset_o) level_q <= '0;
    else if (lvl_ok)      level_q[lvl_bit] <= lvl_state_i;
  end

  always_comb begin
    rdata_o = '0;
    err_o   = 1'b0;
    if (req_i && !we_i) begin
      case (addr_i)
        REG_AW'(OFF_SPARE0), REG_AW'(OFF_SPARE1): rdata_o = '0;
        REG_AW'(OFF_CTRL):  rdata_o = ctrl_q;
        REG_AW'(OFF_PAGE):  rdata_o = page_q;
        REG_AW'(OFF_NADDR): rdata_o = naddr_q;
        REG_AW'(OFF_IOFF):  rdata_o = ioff_q;
        REG_AW'(OFF_LEVEL): rdata_o = level_q;
        default: begin
          rdata_o = '1;
          err_o   = 1'b1;
        end
      endcase
    end
  end

  assign legacy_o    = ctrl_q[LEGACY_BIT];
  assign naddr_o     = naddr_q;
  assign ioff_o      = ioff_q[63:32];
  assign page_map_o  = page_q[VALID_BIT];
  assign page_addr_o = page_addr_q;
endmodule

// File: rtl/inr_fifo.sv
module inr_fifo #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned W     = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] din_i,
  input  logic         pop_i,
  input  logic         flush_i,
  output logic [W-1:0] dout_o,
  output logic         empty_o,
  output logic         full_o
);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [PW-1:0] wr_ptr_q, rd_ptr_q;
  logic [CW-1:0] cnt_q;
  logic          push_ok, pop_ok;

  assign empty_o = cnt_q == '0;
  assign full_o  = cnt_q == CW'(DEPTH);
  assign push_ok = push_i & ~full_o;
  assign pop_ok  = pop_i & ~empty_o;
  assign dout_o  = mem_q[rd_ptr_q];

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              mem_q[g] <= '0;
      else if (push_ok && wr_ptr_q == PW'(g))   mem_q[g] <= din_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else if (flush_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (push_ok) wr_ptr_q <= nxt(wr_ptr_q);
      if (pop_ok)  rd_ptr_q <= nxt(rd_ptr_q);
      case ({push_ok, pop_ok})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/inr_sender.sv
module inr_sender
  import inr_pkg::*;
#(
  parameter int unsigned SRC_W     = 4,
  parameter logic [63:0] TRIG_FLAG = 64'h0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             q_empty_i,
  input  logic [SRC_W-1:0] q_src_i,
  output logic             q_pop_o,
  input  logic             legacy_i,
  input  logic [63:0]      naddr_i,
  input  logic [31:0]      ioff_i,
  output logic             wr_req_o,
  output logic [63:0]      wr_addr_o,
  output logic [63:0]      wr_data_o,
  input  logic             wr_ready_i,
  input  logic             wr_rsp_valid_i,
  input  logic             wr_rsp_err_i,
  output logic             err_sticky_o
);
  snd_state_e  state_q;
  logic [63:0] addr_q, data_q, word;
  logic        err_q, go;

  assign word    = TRIG_FLAG | {32'b0, ioff_i} | 64'(q_src_i);
  assign q_pop_o = (state_q == SND_IDLE) & ~q_empty_i;
  // entries whose conditions lapsed while queued are dropped
  assign go      = q_pop_o & naddr_i[VALID_BIT] & ~legacy_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SND_IDLE;
      addr_q  <= '0;
      data_q  <= '0;
      err_q   <= 1'b0;
    end else begin
      case (state_q)
        SND_IDLE: if (go) begin
          addr_q  <= {1'b0, naddr_i[62:0]};
          data_q  <= be_lanes(word);
          state_q <= SND_REQ;
        end
        SND_REQ:  if (wr_ready_i) state_q <= SND_WAIT;
        SND_WAIT: if (wr_rsp_valid_i) begin
          if (wr_rsp_err_i) err_q <= 1'b1;
          state_q <= SND_IDLE;
        end
        default:  state_q <= SND_IDLE;
      endcase
    end
  end

  assign wr_req_o     = state_q == SND_REQ;
  assign wr_addr_o    = addr_q;
  assign wr_data_o    = data_q;
  assign err_sticky_o = err_q;
endmodule

// File: rtl/intr_notify_gen.sv
module intr_notify_gen #(
  parameter int unsigned NUM_SRC    = 14,
  parameter int unsigned FIFO_DEPTH = 4,
  parameter int unsigned REG_AW     = 8,
  parameter logic [63:0] TRIG_FLAG  = 64'h0,
  localparam int unsigned SRC_W     = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_req_i,
  input  logic              reg_we_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [63:0]       reg_wdata_i,
  output logic [63:0]       reg_rdata_o,
  output logic              reg_err_o,
  input  logic              lvl_evt_i,
  input  logic [SRC_W-1:0]  lvl_src_i,
  input  logic              lvl_state_i,
  input  logic              trig_valid_i,
  input  logic [SRC_W-1:0]  trig_src_i,
  output logic              wr_req_o,
  output logic [63:0]       wr_addr_o,
  output logic [63:0]       wr_data_o,
  input  logic              wr_ready_i,
  input  logic              wr_rsp_valid_i,
  input  logic              wr_rsp_err_i,
  output logic              err_sticky_o,
  output logic              page_map_o,
  output logic [63:0]       page_addr_o
);
  logic              legacy, src_reset;
  logic [63:0]       naddr;
  logic [31:0]       ioff;
  logic              q_push, q_pop, q_empty, q_full;
  logic [SRC_W-1:0]  q_src;

  inr_regs #(.NUM_SRC(NUM_SRC), .SRC_W(SRC_W), .REG_AW(REG_AW)) i_regs (
    .clk_i, .rst_ni,
    .req_i(reg_req_i), .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .rdata_o(reg_rdata_o), .err_o(reg_err_o),
    .lvl_evt_i, .lvl_src_i, .lvl_state_i,
    .legacy_o(legacy), .src_reset_o(src_reset), .naddr_o(naddr), .ioff_o(ioff),
    .page_map_o, .page_addr_o
  );

  assign q_push = trig_valid_i & naddr[63] & ~legacy & ~src_reset
                & (32'(trig_src_i) < NUM_SRC);

  inr_fifo #(.DEPTH(FIFO_DEPTH), .W(SRC_W)) i_fifo (
    .clk_i, .rst_ni,
    .push_i(q_push), .din_i(trig_src_i), .pop_i(q_pop), .flush_i(src_reset),
    .dout_o(q_src), .empty_o(q_empty), .full_o(q_full)
  );

  inr_sender #(.SRC_W(SRC_W), .TRIG_FLAG(TRIG_FLAG)) i_sender (
    .clk_i, .rst_ni,
    .q_empty_i(q_empty), .q_src_i(q_src), .q_pop_o(q_pop),
    .legacy_i(legacy), .naddr_i(naddr), .ioff_i(ioff),
    .wr_req_o, .wr_addr_o, .wr_data_o, .wr_ready_i, .wr_rsp_valid_i, .wr_rsp_err_i,
    .err_sticky_o
  );

  logic unused_full;
  assign unused_full = q_full;
endmodule

// File: rtl/inr_chk.sv
module inr_chk
  import inr_pkg::*;
#(
  parameter int unsigned REG_AW = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              reg_req_i,
  input logic              reg_we_i,
  input logic [REG_AW-1:0] reg_addr_i,
  input logic [63:0]       reg_wdata_i,
  input logic [63:0]       reg_rdata_o,
  input logic              reg_err_o,
  input logic              wr_req_o,
  input logic              wr_ready_i,
  input logic [63:0]       wr_addr_o,
  input logic [63:0]       wr_data_o,
  input logic              err_sticky_o,
  input logic              legacy,
  input logic              q_empty
);
  logic unlisted, ctrl_srst_wr;
  assign unlisted = !(reg_addr_i inside {REG_AW'(OFF_SPARE0), REG_AW'(OFF_SPARE1),
                      REG_AW'(OFF_CTRL), REG_AW'(OFF_PAGE), REG_AW'(OFF_NADDR),
                      REG_AW'(OFF_IOFF), REG_AW'(OFF_LEVEL)});
  assign ctrl_srst_wr = reg_req_i && reg_we_i && reg_addr_i == REG_AW'(OFF_CTRL)
                        && reg_wdata_i[SRST_BIT];

  // R3
  unlisted_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_req_i && !reg_we_i && unlisted |-> reg_err_o && reg_rdata_o == '1);
  // R9
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_req_o && !wr_ready_i |=> wr_req_o && $stable(wr_addr_o) && $stable(wr_data_o));
  // R7
  addr_flag_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_req_o |-> !wr_addr_o[63]);
  // R11
  sticky_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_sticky_o |=> err_sticky_o);
  // R6
  srst_flush_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_srst_wr |=> q_empty);
  // R5
  legacy_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    legacy && q_empty |=> q_empty);
endmodule

bind intr_notify_gen inr_chk #(.REG_AW(REG_AW)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .reg_req_i(reg_req_i), .reg_we_i(reg_we_i),
  .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o),
  .reg_err_o(reg_err_o), .wr_req_o(wr_req_o), .wr_ready_i(wr_ready_i),
  .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o), .err_sticky_o(err_sticky_o),
  .legacy(legacy), .q_empty(q_empty)
);

// File: tb/test_intr_notify_gen.sv
module test_intr_notify_gen;
  localparam int CLK_PERIOD = 10;
  localparam int SW = 4;

  logic clk = 0, rst_ni = 0;
  logic reg_req_i = 0, reg_we_i = 0;
  logic [7:0]  reg_addr_i = 0;
  logic [63:0] reg_wdata_i = 0, reg_rdata_o;
  logic        reg_err_o;
  logic        lvl_evt_i = 0, lvl_state_i = 0, trig_valid_i = 0;
  logic [SW-1:0] lvl_src_i = 0, trig_src_i = 0;
  logic        wr_req_o, wr_ready_i = 0, wr_rsp_valid_i = 0, wr_rsp_err_i = 0;
  logic [63:0] wr_addr_o, wr_data_o, page_addr_o;
  logic        err_sticky_o, page_map_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  intr_notify_gen i_intr_notify_gen (
    .clk_i(clk), .rst_ni, .reg_req_i, .reg_we_i, .reg_addr_i, .reg_wdata_i,
    .reg_rdata_o, .reg_err_o, .lvl_evt_i, .lvl_src_i, .lvl_state_i,
    .trig_valid_i, .trig_src_i, .wr_req_o, .wr_addr_o, .wr_data_o, .wr_ready_i,
    .wr_rsp_valid_i, .wr_rsp_err_i, .err_sticky_o, .page_map_o, .page_addr_o
  );

  int n_chk = 0, n_fail = 0, n_wr = 0, ready_lat = 0;
  logic err_mode = 0, done = 0;
  logic [63:0] cap_addr [32];
  logic [63:0] cap_data [32];

  task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] swap8(input logic [63:0] v);
    logic [63:0] r;
    for (int i = 0; i < 8; i++) r[8*i +: 8] = v[63-8*i -: 8];
    return r;
  endfunction

  // responder: stalls ready_lat cycles, then accepts and answers
  initial forever begin
    @(negedge clk);
    if (wr_req_o && n_wr < 32) begin
      cap_addr[n_wr] = wr_addr_o;
      cap_data[n_wr] = wr_data_o;
      for (int s = 0; s < ready_lat; s++) begin
        @(negedge clk);
        chk(wr_req_o && wr_addr_o == cap_addr[n_wr] && wr_data_o == cap_data[n_wr],
            "R9 hold", wr_data_o, cap_data[n_wr]);
      end
      wr_ready_i = 1;
      @(negedge clk);
      wr_ready_i = 0;
      chk(!wr_req_o, "R9 one outstanding", 64'(wr_req_o), 64'h0);
      @(negedge clk);
      wr_rsp_valid_i = 1;
      wr_rsp_err_i = err_mode;
      n_wr++;
      @(negedge clk);
      wr_rsp_valid_i = 0;
      wr_rsp_err_i = 0;
    end
  end

  task automatic reg_wr(input logic [7:0] a, input logic [63:0] d);
    @(negedge clk);
    reg_req_i = 1; reg_we_i = 1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk);
    reg_req_i = 0; reg_we_i = 0;
  endtask

  task automatic reg_rd(input logic [7:0] a, output logic [63:0] d, output logic e);
    @(negedge clk);
    reg_req_i = 1; reg_we_i = 0; reg_addr_i = a;
    #(CLK_PERIOD/4);
    d = reg_rdata_o; e = reg_err_o;
    reg_req_i = 0;
  endtask

  task automatic trig(input int s);
    @(negedge clk);
    trig_valid_i = 1; trig_src_i = SW'(s);
    @(negedge clk);
    trig_valid_i = 0;
  endtask

  task automatic lvl(input int s, input logic st);
    @(negedge clk);
    lvl_evt_i = 1; lvl_src_i = SW'(s); lvl_state_i = st;
    @(negedge clk);
    lvl_evt_i = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_wr(input int target);
    for (int i = 0; i < 80 && n_wr < target; i++) @(negedge clk);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  endtask

  typedef struct packed {
    logic        we;
    logic [7:0]  addr;
    logic [63:0] data;
    logic [63:0] exp;
    logic        err;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 8'h58, 64'h0000_0000_0000_00a5, 64'h0000_0000_0000_00a5, 1'b0}, // R2
    '{1'b1, 8'h60, 64'h0000_0000_0123_4000, 64'h0000_0000_0123_4000, 1'b0}, // R2
    '{1'b1, 8'h68, 64'h0000_0000_0010_0000, 64'h0000_0000_0010_0000, 1'b0}, // R2
    '{1'b1, 8'h70, 64'h1234_5678_9abc_def0, 64'h1234_5678_9abc_def0, 1'b0}, // R2
    '{1'b1, 8'h20, 64'hffff_ffff_ffff_ffff, 64'h0,                   1'b0}, // R2 ignored
    '{1'b1, 8'h28, 64'hffff_ffff_ffff_ffff, 64'h0,                   1'b0}, // R2 ignored
    '{1'b1, 8'h78, 64'hffff_ffff_ffff_ffff, 64'h0,                   1'b0}, // R2 level not writable
    '{1'b0, 8'h40, 64'h0,                   64'hffff_ffff_ffff_ffff, 1'b1}, // R3
    '{1'b0, 8'h6c, 64'h0,                   64'hffff_ffff_ffff_ffff, 1'b1}, // R3 misaligned
    '{1'b0, 8'h80, 64'h0,                   64'hffff_ffff_ffff_ffff, 1'b1}  // R3
  };

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [63:0] d;
    logic e;
    int base;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!wr_req_o && !err_sticky_o && !page_map_o, "R1 outputs",
        {61'b0, wr_req_o, err_sticky_o, page_map_o}, 64'h0);
    rst_ni = 1;
    reg_rd(8'h58, d, e); chk(d == 0 && !e, "R1 ctrl", d, 64'h0);
    reg_rd(8'h68, d, e); chk(d == 0 && !e, "R1 naddr", d, 64'h0);
    reg_rd(8'h78, d, e); chk(d == 0 && !e, "R1 level", d, 64'h0);

    // R2 / R3 vector walk
    for (int i = 0; i < NV; i++) begin
      if (VECS[i].we) reg_wr(VECS[i].addr, VECS[i].data);
      reg_rd(VECS[i].addr, d, e);
      chk(d == VECS[i].exp && e == VECS[i].err, VECS[i].err ? "R3 vector" : "R2 vector",
          d, VECS[i].exp);
    end
    reg_wr(8'h58, 64'h0);

    // R8 address not valid
    base = n_wr;
    trig(3); idle(15);
    chk(n_wr == base, "R8 no write", 64'(n_wr), 64'(base));

    // R7 notification contents
    reg_wr(8'h68, 64'h8000_0000_dead_b000);
    reg_wr(8'h70, 64'h0000_0100_0000_0000);
    base = n_wr;
    trig(5); wait_wr(base + 1);
    chk(n_wr == base + 1, "R7 count", 64'(n_wr), 64'(base + 1));
    chk(cap_addr[base] == 64'h0000_0000_dead_b000, "R7 addr", cap_addr[base], 64'h0000_0000_dead_b000);
    chk(cap_data[base] == swap8(64'h105), "R7 data", cap_data[base], swap8(64'h105));

    // R9 stalled handshake
    ready_lat = 3;
    base = n_wr;
    trig(9); wait_wr(base + 1);
    chk(n_wr == base + 1 && cap_data[base] == swap8(64'h109), "R9 stalled write", cap_data[base], swap8(64'h109));

    // R10 ordering and overflow: one in flight plus four queued, sixth dropped
    ready_lat = 2;
    base = n_wr;
    @(negedge clk);
    for (int s = 0; s < 6; s++) begin
      trig_valid_i = 1; trig_src_i = SW'(s);
      @(negedge clk);
    end
    trig_valid_i = 0;
    idle(100);
    chk(n_wr == base + 5, "R10 overflow count", 64'(n_wr), 64'(base + 5));
    for (int s = 0; s < 5; s++)
      chk(cap_data[base+s] == swap8(64'h100 | 64'(s)), "R10 order", cap_data[base+s], swap8(64'h100 | 64'(s)));
    ready_lat = 0;

    // R4 level bits
    lvl(0, 1);
    reg_rd(8'h78, d, e); chk(d == 64'h8000_0000_0000_0000, "R4 set src0", d, 64'h8000_0000_0000_0000);
    lvl(13, 1); lvl(0, 0);
    reg_rd(8'h78, d, e); chk(d == 64'h0004_0000_0000_0000, "R4 src13 only", d, 64'h0004_0000_0000_0000);

    // R5 legacy mode ignores events
    reg_wr(8'h58, 64'h8000_0000_0000_0000);
    lvl(2, 1); lvl(13, 0);
    reg_rd(8'h78, d, e); chk(d == 64'h0004_0000_0000_0000, "R5 level held", d, 64'h0004_0000_0000_0000);
    base = n_wr;
    trig(4); idle(15);
    chk(n_wr == base, "R5 no write", 64'(n_wr), 64'(base));
    reg_wr(8'h58, 64'h0);

    // R6 source reset during a stalled write with a full queue
    lvl(6, 1);
    ready_lat = 10;
    base = n_wr;
    @(negedge clk);
    for (int s = 8; s < 12; s++) begin
      trig_valid_i = 1; trig_src_i = SW'(s);
      @(negedge clk);
    end
    trig_valid_i = 0;
    reg_wr(8'h58, 64'h4000_0000_0000_0000);
    reg_rd(8'h78, d, e); chk(d == 64'h0, "R6 level cleared", d, 64'h0);
    reg_rd(8'h58, d, e); chk(d == 64'h4000_0000_0000_0000, "R6 ctrl stored", d, 64'h4000_0000_0000_0000);
    idle(60);
    chk(n_wr == base + 1, "R6 queue dropped", 64'(n_wr), 64'(base + 1));
    chk(cap_data[base] == swap8(64'h108), "R6 in-flight kept", cap_data[base], swap8(64'h108));
    ready_lat = 0;
    reg_wr(8'h58, 64'h0);

    // R11 error response
    err_mode = 1;
    base = n_wr;
    trig(1); wait_wr(base + 1); idle(3);
    err_mode = 0;
    chk(err_sticky_o, "R11 sticky set", 64'(err_sticky_o), 64'h1);
    idle(20);
    chk(n_wr == base + 1, "R11 no retry", 64'(n_wr), 64'(base + 1));
    trig(2); wait_wr(base + 2); idle(3);
    chk(err_sticky_o, "R11 sticky held", 64'(err_sticky_o), 64'h1);

    // R12 page mapping
    reg_wr(8'h60, 64'h8000_0000_0004_0000);
    chk(page_map_o && page_addr_o == 64'h4_0000, "R12 map", page_addr_o, 64'h4_0000);
    reg_wr(8'h60, 64'h8000_0000_0008_0000);
    chk(page_map_o && page_addr_o == 64'h4_0000, "R12 remap ignored", page_addr_o, 64'h4_0000);
    reg_rd(8'h60, d, e); chk(d == 64'h8000_0000_0008_0000, "R12 readback", d, 64'h8000_0000_0008_0000);
    reg_wr(8'h60, 64'h0);
    chk(!page_map_o, "R12 unmap", 64'(page_map_o), 64'h0);
    reg_wr(8'h60, 64'h8000_0000_0008_0000);
    chk(page_map_o && page_addr_o == 64'h8_0000, "R12 map new", page_addr_o, 64'h8_0000);

    idle(5);
    summary();
  end
endmodule